// File: doc/BRIEF.md
# SIMD Signed-Count Lane Shifter

This block shifts every lane of a 128-bit data vector by an amount taken from the matching lane of a 128-bit count vector. All lanes share one width: 8, 16, 32 or 64 bits. The low byte of each count lane is read as a signed number. Its sign chooses the direction: zero or positive shifts left, negative shifts right by the magnitude. A mode bit selects logical (unsigned) or arithmetic (signed) right shifts.

Counts that reach or pass the lane width saturate rather than wrap. Over-range left shifts and unsigned right shifts give zero. Signed right shifts fill the lane with its sign bit. A half-width mode keeps only the low 64 bits of the result and clears the rest.

The result passes through one register, and a valid strobe travels alongside it. The block is meant to sit in a vector execute stage, fed straight from operand read.

Top module: `simd_lane_shifter`

## Requirements
- R1: Only bits 7:0 of each count lane are used, read as a two's-complement value from -128 to +127. Count lane bits above 7 have no effect on the result.
- R2: A count of zero or more shifts the data lane left and fills with zeros. A negative count shifts it right by the count's magnitude.
- R3: A left shift with count at or above the lane width gives an all-zero lane, in both signed and unsigned mode.
- R4: In unsigned mode (signed_mode = 0), a right shift with magnitude at or above the lane width gives an all-zero lane. A magnitude of width minus one keeps only the top data bit.
- R5: In signed mode (signed_mode = 1), the right-shift magnitude is clamped to lane width minus one. An over-range right shift therefore gives all ones for negative data and all zeros for non-negative data.
- R6: A count byte of 0x80 is a right shift of magnitude 128. It gives zero in unsigned mode and sign fill in signed mode.
- R7: lane_sz selects the lane width: 2'b00 is 8 bits, 2'b01 is 16, 2'b10 is 32 and 2'b11 is 64. Every lane uses the same width and mode.
- R8: When half_mode = 1, result bits 127:64 are zero and bits 63:0 are computed as usual.
- R9: result and out_valid appear one clock after the inputs with in_valid set, and out_valid is high for exactly that one cycle per in_valid. A synchronous active-high rst clears result and out_valid.
- R10: Lanes are independent. No bit shifted out of one lane appears in a neighbouring lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands valid this cycle |
| lane_sz | input | 2 | Lane width code |
| signed_mode | input | 1 | 1: arithmetic right shift, 0: logical |
| half_mode | input | 1 | 1: clear result bits 127:64 |
| data_in | input | 128 | Data vector |
| count_in | input | 128 | Per-lane shift counts |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Registered shifted vector |

## Verification
The assertions check on every cycle the properties that hold for any input:
- the valid strobe follows in_valid one cycle later, and reset clears both outputs;
- the upper half of the result is zero after a half-mode operation;
- a zero count in the first 64-bit lane passes the data through unchanged;
- a 0x80 count in lane 0 gives zero in unsigned mode, and the sign byte in signed 8-bit mode.

Only the bench's scenarios show the shift results that depend on the data:
- the exact shifted values at each lane width;
- the saturation boundaries at width and width minus one;
- that the upper count bits are ignored;
- that bits do not leak across lane borders when lanes use different counts.

// File: rtl/lshift_pkg.sv
package lshift_pkg;
   typedef enum logic [1:0] {
      LW_8  = 2'b00,
      LW_16 = 2'b01,
      LW_32 = 2'b10,
      LW_64 = 2'b11
   } lane_width_e;

   localparam int CNT_BITS   = 8;
   localparam int NUM_WIDTHS = 4;
   localparam int MIN_LANE_W = 8;
endpackage

// File: rtl/lshift_lane.sv
module lshift_lane
   import lshift_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [W-1:0]        data,
   input  logic [CNT_BITS-1:0] cnt,
   input  logic                sgn,
   output logic [W-1:0]        res
);
   localparam int              AW  = $clog2(W);
   localparam logic [8:0]      WV  = 9'(W);
   localparam logic [AW-1:0]   TOP = AW'(W - 1);

   if (W < MIN_LANE_W || (W & (W - 1)) != 0) begin : g_bad_w
      $error("lshift_lane: W must be a power of two of at least 8");
   end

   logic [8:0] cnt_sx;
   logic [8:0] mag;
   logic       is_right;

   assign cnt_sx   = {cnt[CNT_BITS-1], cnt};
   assign mag      = ~cnt_sx + 9'd1;
   assign is_right = cnt[CNT_BITS-1];

   always_comb begin
      res = '0;
      if (!is_right) begin
         if (cnt_sx < WV) res = data << cnt[AW-1:0];
      end else if (sgn) begin
         if (mag >= WV) res = W'($signed(data) >>> TOP);
         else           res = W'($signed(data) >>> mag[AW-1:0]);
      end else begin
         if (mag < WV)  res = data >> mag[AW-1:0];
      end
   end
endmodule

// File: rtl/lshift_lane_array.sv
module lshift_lane_array
   import lshift_pkg::*;
#(
   parameter int VEC_W = 128,
   parameter int W     = 8
) (
   input  logic [VEC_W-1:0] data,
   input  logic [VEC_W-1:0] count,
   input  logic             sgn,
   output logic [VEC_W-1:0] res
);
   localparam int LANES = VEC_W / W;

   if (VEC_W % W != 0) begin : g_bad_split
      $error("lshift_lane_array: VEC_W must be a multiple of W");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      lshift_lane #(.W(W)) u_lane (
         .data (data[i*W +: W]),
         .cnt  (count[i*W +: CNT_BITS]),
         .sgn  (sgn),
         .res  (res[i*W +: W])
      );
      if (W > CNT_BITS) begin : g_hi
         logic unused_cnt_hi;
         assign unused_cnt_hi = ^count[i*W+CNT_BITS +: W-CNT_BITS];
      end
   end
endmodule

// File: rtl/simd_lane_shifter.sv
module simd_lane_shifter
   import lshift_pkg::*;
#(
   parameter int VEC_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [1:0]       lane_sz,
   input  logic             signed_mode,
   input  logic             half_mode,
   input  logic [VEC_W-1:0] data_in,
   input  logic [VEC_W-1:0] count_in,
   output logic             out_valid,
   output logic [VEC_W-1:0] result
);
   localparam int HALF_W = VEC_W / 2;

   if (VEC_W % 128 != 0) begin : g_bad_vec
      $error("simd_lane_shifter: VEC_W must be a multiple of 128");
   end

   logic [VEC_W-1:0] per_width [NUM_WIDTHS];
   logic [VEC_W-1:0] shifted;
   logic [VEC_W-1:0] next_res;

   for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
      lshift_lane_array #(.VEC_W(VEC_W), .W(MIN_LANE_W << g)) u_arr (
         .data  (data_in),
         .count (count_in),
         .sgn   (signed_mode),
         .res   (per_width[g])
      );
   end

   always_comb begin
      unique case (lane_width_e'(lane_sz))
         LW_8:    shifted = per_width[0];
         LW_16:   shifted = per_width[1];
         LW_32:   shifted = per_width[2];
         default: shifted = per_width[3];
      endcase
      next_res = shifted;
      if (half_mode) next_res[VEC_W-1:HALF_W] = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end

   // R9: reset clears the output stage
   a_r9_reset_clear: assert property (@(posedge clk)
      rst |=> (!out_valid && result == '0));
   // R9: valid travels one cycle
   a_r9_valid_follow: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r9_valid_single: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R8: upper half is cleared in half mode
   a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
      (in_valid && half_mode) |=> (result[VEC_W-1:HALF_W] == '0));
   // R2: zero count in the first 64-bit lane passes the data through
   a_r2_zero_count: assert property (@(posedge clk) disable iff (rst)
      (in_valid && lane_sz == 2'b11 && count_in[7:0] == 8'h00)
      |=> (result[63:0] == $past(data_in[63:0])));
   // R6: count 0x80 in unsigned mode gives zero in lane 0
   a_r6_min_unsigned: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !signed_mode && count_in[7:0] == 8'h80)
      |=> (result[7:0] == 8'h00));
   // R5: count 0x80 in signed 8-bit mode fills lane 0 with the sign
   a_r5_min_sign_fill: assert property (@(posedge clk) disable iff (rst)
      (in_valid && signed_mode && lane_sz == 2'b00 && count_in[7:0] == 8'h80)
      |=> (result[7:0] == {8{$past(data_in[7])}}));
endmodule

// File: tb/simd_lane_shifter_test.sv
`timescale 1ns/1ps
module simd_lane_shifter_test;
   typedef struct packed {
      logic [31:0]  tag;
      logic [1:0]   sz;
      logic         sg;
      logic         hf;
      logic [127:0] d;
      logic [127:0] c;
      logic [127:0] e;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VECS [NV] = '{
      '{"R2",  2'b00, 1'b0, 1'b0, {16{8'h81}}, {16{8'h01}}, {16{8'h02}}},
      '{"R10", 2'b00, 1'b0, 1'b0, {16{8'h81}}, {16{8'hFF}}, {16{8'h40}}},
      '{"R5",  2'b00, 1'b1, 1'b0, {16{8'h81}}, {16{8'hFF}}, {16{8'hC0}}},
      '{"R6",  2'b00, 1'b1, 1'b0, {16{8'h81}}, {16{8'h80}}, {16{8'hFF}}},
      '{"R6",  2'b00, 1'b0, 1'b0, {16{8'h81}}, {16{8'h80}}, {16{8'h00}}},
      '{"R1",  2'b01, 1'b0, 1'b0, {8{16'h1234}}, {8{16'h0F04}}, {8{16'h2340}}},
      '{"R3",  2'b01, 1'b0, 1'b0, {8{16'h1234}}, {8{16'h0010}}, 128'h0},
      '{"R3",  2'b01, 1'b1, 1'b0, {8{16'h8001}}, {8{16'h0010}}, 128'h0},
      '{"R5",  2'b01, 1'b1, 1'b0, {8{16'h8001}}, {8{16'h00F0}}, {8{16'hFFFF}}},
      '{"R4",  2'b01, 1'b0, 1'b0, {8{16'h8001}}, {8{16'h00F0}}, 128'h0},
      '{"R4",  2'b01, 1'b0, 1'b0, {8{16'h8001}}, {8{16'h00F1}}, {8{16'h0001}}},
      '{"R5",  2'b10, 1'b1, 1'b0, {4{32'h7FFF0000}}, {4{32'h000000E0}}, 128'h0},
      '{"R1",  2'b10, 1'b1, 1'b0, {4{32'h80000000}}, {4{32'hFFFFFFFF}}, {4{32'hC0000000}}},
      '{"R7",  2'b11, 1'b0, 1'b0, {2{64'h0123456789ABCDEF}}, {2{64'h4}}, {2{64'h123456789ABCDEF0}}},
      '{"R3",  2'b11, 1'b0, 1'b0, {2{64'h1}}, {2{64'h3F}}, {2{64'h8000000000000000}}},
      '{"R3",  2'b11, 1'b0, 1'b0, {2{64'h1}}, {2{64'h40}}, 128'h0},
      '{"R8",  2'b00, 1'b0, 1'b1, {16{8'h81}}, {16{8'h01}}, {64'h0, {8{8'h02}}}},
      '{"R7",  2'b11, 1'b1, 1'b0, {2{64'hF000000000000000}}, {2{64'hFC}}, {2{64'hFF00000000000000}}},
      '{"R10", 2'b00, 1'b0, 1'b0, {16{8'hFF}}, {8{16'h07F9}}, {8{16'h8001}}}
   };

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [1:0]   lane_sz = 2'b00;
   logic         signed_mode = 1'b0;
   logic         half_mode = 1'b0;
   logic [127:0] data_in = '0;
   logic [127:0] count_in = '0;
   logic         out_valid;
   logic [127:0] result;
   int           n_vec = 0;
   int           n_bad = 0;

   always #2.5 clk = ~clk;

   simd_lane_shifter uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sz(lane_sz),
      .signed_mode(signed_mode), .half_mode(half_mode),
      .data_in(data_in), .count_in(count_in),
      .out_valid(out_valid), .result(result)
   );

   task automatic check(input logic [127:0] act, input logic [127:0] exp,
                        input string req);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   initial begin
      repeat (40000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check({127'h0, out_valid}, 128'h0, "R9 out_valid in reset");
      check(result, 128'h0, "R9 result in reset");
      rst = 1'b0;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         lane_sz     = VECS[i].sz;
         signed_mode = VECS[i].sg;
         half_mode   = VECS[i].hf;
         data_in     = VECS[i].d;
         count_in    = VECS[i].c;
         in_valid    = 1'b1;
         @(negedge clk);
         in_valid = 1'b0;
         check({127'h0, out_valid}, 128'h1, "R9 out_valid after in_valid");
         check(result, VECS[i].e, $sformatf("%s vector %0d", VECS[i].tag, i));
      end

      // R9: one strobe per in_valid
      @(negedge clk);
      check({127'h0, out_valid}, 128'h0, "R9 out_valid drops");

      // R9: reset clears a loaded result
      lane_sz = 2'b00; signed_mode = 1'b0; half_mode = 1'b0;
      data_in = {16{8'h81}}; count_in = {16{8'h01}}; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(result, {16{8'h02}}, "R9 load before reset");
      rst = 1'b1;
      @(negedge clk);
      check(result, 128'h0, "R9 result cleared");
      check({127'h0, out_valid}, 128'h0, "R9 out_valid cleared");
      rst = 1'b0;
      @(negedge clk);

      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule